// File: doc/BRIEF.md
# Dual-Channel Interval Timer with Prescaler

The block holds two count channels, A and B, behind one word-addressed register port. Each channel counts up or down between zero and a programmed limit, raises a timeout flag at the wrap and a match flag when the count lands on a programmed value. It either reloads and keeps counting (periodic) or stops and drops its own enable bit (one-shot). In split configuration both channels are 16 bits wide and an 8-bit prescaler can slow each down-counting channel. A configuration code instead fuses the two halves into one 32-bit counter. Channel A drives it and channel B's value address reads the upper half.

Four sticky status bits collect the events. A mask selects which of them reach the single interrupt output. Software clears bits by writing ones to a clear address. Register reads are combinational and writes take effect at the clock edge where `we_i` is high.

Top module: `ivt_timer`

## Requirements
- R1: After reset: configuration (addr 0) reads 0, control (addr 1) reads 0, load A (addr 4) and match A (addr 6) read 0xFFFFFFFF, status (addr 12) reads 0 and `irq_o` is low.
- R2: With mode field [1:0] of the channel's mode register (A: addr 2, B: addr 3) set to 10 and bit 2 clear, the count starts at the load value one cycle after the enable write. It decrements once per step and, on the step after it reads zero, reloads the load value and sets the timeout status bit (A: bit 0, B: bit 2).
- R3: With mode bit 2 set, the count starts at zero, increments to the load value, and on the next step returns to zero and sets the timeout bit.
- R4: Mode 01 is one-shot: the timeout step clears the channel's control bit (A: bit 0, B: bit 1) and the count then stays put.
- R5: Mode 10 is periodic: counting goes on after every timeout.
- R6: Modes 00 and 11 never count, even when the channel is enabled.
- R7: In split configuration with down-counting, the channel steps once every (prescale + 1) cycles, with prescale A at addr 8 and B at addr 9. Up-counting ignores the prescaler.
- R8: Configuration code 000 makes one 32-bit counter controlled by channel A. Value B (addr 11) reads the upper 16 bits of value A (addr 10), borrows cross the halves, and the prescaler is not used. Any other code (e.g. 100) selects two 16-bit channels.
- R9: When a step lands the count on the match value, the match bit is set (A: bit 1, B: bit 3). Split mode compares only the low 16 bits. Match B is at addr 7.
- R10: Status bits are set regardless of the mask (addr 13). Masked status (addr 14) is status AND mask, and `irq_o` is the OR of the masked bits.
- R11: Writing ones to addr 15 clears those status bits. An event in the same cycle as the clear leaves its bit set.
- R12: A write to a value register loads the counter at that edge, so it reads back the next cycle. In split mode only the low 16 bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | OR of masked status bits |

## Verification
A fault in a channel's count register shows up on the next read of its value address and, within one load period, as a timeout bit that sets a step early or late. A stuck prescaler changes the spacing of steps on the first prescaled step, two cycles after enable. A lost one-shot clear shows up one cycle after the timeout, in the control register read. A bad clear/event priority shows up only on the cycle of the collision, so the bench forces that collision on purpose.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int DW  = 32;
  localparam int HW  = 16;
  localparam int PW  = 8;
  localparam int AW  = 4;
  localparam int NCH = 2;
  localparam int NEV = 2 * NCH;

  typedef enum logic [AW-1:0] {
    A_CFG = 4'd0, A_CTRL = 4'd1, A_MODE = 4'd2, A_LOAD = 4'd4,
    A_MATCH = 4'd6, A_PRE = 4'd8, A_VAL = 4'd10,
    A_STAT = 4'd12, A_MASK = 4'd13, A_MSTAT = 4'd14, A_CLR = 4'd15
  } addr_e;

  localparam logic [2:0] CFG_JOIN = 3'b000;
  localparam logic [1:0] MODE_ONE = 2'b01;
  localparam logic [1:0] MODE_PER = 2'b10;
endpackage

// File: rtl/ivt_chan.sv
module ivt_chan #(
  parameter int W  = 32,
  parameter int HW = 16,
  parameter int PW = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         wide_i,
  input  logic         up_i,
  input  logic         oneshot_i,
  input  logic [W-1:0] load_i,
  input  logic [W-1:0] match_i,
  input  logic [PW-1:0] pre_i,
  input  logic         set_i,
  input  logic [W-1:0] set_val_i,
  output logic [W-1:0] cnt_o,
  output logic         tmo_o,
  output logic         mat_o,
  output logic         done_o
);
  localparam logic [W-1:0] LO_MASK = W'({HW{1'b1}});

  logic [W-1:0]  cnt_q, nxt, msk, lim;
  logic [PW-1:0] pre_q;
  logic          run_q, start, use_pre, tick, term;

  assign msk     = wide_i ? '1 : LO_MASK;
  assign lim     = load_i & msk;
  assign start   = run_i & ~run_q;
  assign use_pre = ~wide_i & ~up_i;
  assign tick    = run_i & ~start & ~set_i & (~use_pre | (pre_q == '0));
  assign term    = up_i ? (cnt_q == lim) : (cnt_q == '0);

  always_comb begin
    if (term) nxt = up_i ? '0 : lim;
    else      nxt = (up_i ? cnt_q + 1'b1 : cnt_q - 1'b1) & msk;
  end

  assign tmo_o  = tick & term;
  assign mat_o  = tick & (nxt == (match_i & msk));
  assign done_o = tmo_o & oneshot_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      pre_q <= '0;
    end else begin
      run_q <= run_i;
      if (set_i)      cnt_q <= set_val_i & msk;
      else if (start) cnt_q <= up_i ? '0 : lim;
      else if (tick)  cnt_q <= nxt;
      if (!run_i || start)  pre_q <= pre_i;
      else if (use_pre)     pre_q <= (pre_q == '0) ? pre_i : pre_q - 1'b1;
    end
  end
endmodule

// File: rtl/ivt_irq.sv
module ivt_irq #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_d_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] raw_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_i) | ev_i;  // event beats clear
      if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = |(raw_q & mask_q);
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [2:0]        cfg_q;
  logic [NCH-1:0]    en_q, run, set, done, tmo, mat;
  logic [2:0]        mode_q  [NCH];
  logic [DATA_W-1:0] load_q  [NCH];
  logic [DATA_W-1:0] match_q [NCH];
  logic [PW-1:0]     pre_q   [NCH];
  logic [DATA_W-1:0] cnt     [NCH];
  logic [NEV-1:0]    ev, clr, raw, mask;
  logic              wide;

  assign wide = (cfg_q == CFG_JOIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      en_q  <= '0;
      for (int i = 0; i < NCH; i++) begin
        mode_q[i]  <= '0;
        load_q[i]  <= '1;
        match_q[i] <= '1;
        pre_q[i]   <= '0;
      end
    end else begin
      if (we_i) begin
        if (addr_i == A_CFG)  cfg_q <= wdata_i[2:0];
        if (addr_i == A_CTRL) en_q  <= wdata_i[NCH-1:0];
        for (int i = 0; i < NCH; i++) begin
          if (addr_i == A_MODE  + ADDR_W'(i)) mode_q[i]  <= wdata_i[2:0];
          if (addr_i == A_LOAD  + ADDR_W'(i)) load_q[i]  <= wdata_i;
          if (addr_i == A_MATCH + ADDR_W'(i)) match_q[i] <= wdata_i;
          if (addr_i == A_PRE   + ADDR_W'(i)) pre_q[i]   <= wdata_i[PW-1:0];
        end
      end
      for (int i = 0; i < NCH; i++)
        if (done[i]) en_q[i] <= 1'b0;  // one-shot self-disable
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam bit CAN_JOIN = (g == 0);
    logic ok_mode;
    assign ok_mode = (mode_q[g][1:0] == MODE_ONE) || (mode_q[g][1:0] == MODE_PER);
    assign run[g] = en_q[g] & ok_mode & (CAN_JOIN | ~wide);
    assign set[g] = we_i & (addr_i == A_VAL + ADDR_W'(g)) & (CAN_JOIN | ~wide);

    ivt_chan #(.W(DATA_W), .HW(HW), .PW(PW)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run[g]),
      .wide_i    (CAN_JOIN & wide),
      .up_i      (mode_q[g][2]),
      .oneshot_i (mode_q[g][1:0] == MODE_ONE),
      .load_i    (load_q[g]),
      .match_i   (match_q[g]),
      .pre_i     (pre_q[g]),
      .set_i     (set[g]),
      .set_val_i (wdata_i),
      .cnt_o     (cnt[g]),
      .tmo_o     (tmo[g]),
      .mat_o     (mat[g]),
      .done_o    (done[g])
    );
    assign ev[2*g]   = tmo[g];
    assign ev[2*g+1] = mat[g];
  end

  assign clr = (we_i && addr_i == A_CLR) ? wdata_i[NEV-1:0] : '0;

  ivt_irq #(.N(NEV)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .clr_i     (clr),
    .mask_we_i (we_i && addr_i == A_MASK),
    .mask_d_i  (wdata_i[NEV-1:0]),
    .raw_o     (raw),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CFG:          rdata_o = DATA_W'(cfg_q);
      A_CTRL:         rdata_o = DATA_W'(en_q);
      A_MODE:         rdata_o = DATA_W'(mode_q[0]);
      A_MODE + 4'd1:  rdata_o = DATA_W'(mode_q[1]);
      A_LOAD:         rdata_o = load_q[0];
      A_LOAD + 4'd1:  rdata_o = load_q[1];
      A_MATCH:        rdata_o = match_q[0];
      A_MATCH + 4'd1: rdata_o = match_q[1];
      A_PRE:          rdata_o = DATA_W'(pre_q[0]);
      A_PRE + 4'd1:   rdata_o = DATA_W'(pre_q[1]);
      A_VAL:          rdata_o = cnt[0];
      A_VAL + 4'd1:   rdata_o = wide ? DATA_W'(cnt[0][DATA_W-1:HW]) : cnt[1];
      A_STAT:         rdata_o = DATA_W'(raw);
      A_MASK:         rdata_o = DATA_W'(mask);
      A_MSTAT:        rdata_o = DATA_W'(raw & mask);
      default:        rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
  parameter int N = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        done_a_i,
  input logic        en_a_i,
  input logic [N-1:0] ev_i,
  input logic [N-1:0] clr_i,
  input logic [N-1:0] raw_i,
  input logic        run_b_i,
  input logic        set_b_i,
  input logic [31:0] set_val_b_i,
  input logic [31:0] cnt_b_i
);
  assert_oneshot_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_a_i |=> !en_a_i);

  assert_event_sets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev_i) |=> ((raw_i & $past(ev_i)) == $past(ev_i)));

  assert_clear_works_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~ev_i)) |=> ((raw_i & $past(clr_i & ~ev_i)) == '0));

  assert_idle_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_b_i && !set_b_i) |=> $stable(cnt_b_i));

  assert_value_load_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_b_i |=> (cnt_b_i == ($past(set_val_b_i) & 32'h0000_FFFF)));
endmodule

bind ivt_timer ivt_timer_chk #(.N(4)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_a_i    (done[0]),
  .en_a_i      (en_q[0]),
  .ev_i        (ev),
  .clr_i       (clr),
  .raw_i       (raw),
  .run_b_i     (run[1]),
  .set_b_i     (set[1]),
  .set_val_b_i (wdata_i),
  .cnt_b_i     (cnt[1])
);

// File: tb/tb_ivt_timer.sv
`timescale 1ns/100ps
module tb_ivt_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  typedef struct { logic [4:0] sel; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  event smp;

  ivt_timer dut (.clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
                 .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o));

  always #4 clk_i = ~clk_i;

  // monitor: compares each queued expectation against the ports
  initial forever begin
    @(smp);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = (it.sel == 5'd16) ? {31'b0, irq_o} : rdata_o;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic chk(input logic [4:0] s, input logic [31:0] e, input string tag);
    item_t it;
    it.sel = s; it.exp = e; it.tag = tag;
    if (s != 5'd16) addr_i = s[3:0];
    q.push_back(it);
    #0.4 -> smp;
    #0.4;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(8 * 200000);
    if (!ended) begin
      errors++;
      checks++;
      $display("FAIL watchdog all-R actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    chk(5'd0, 32'h0, "R1 cfg");
    chk(5'd1, 32'h0, "R1 ctrl");
    chk(5'd4, 32'hFFFF_FFFF, "R1 load");
    chk(5'd6, 32'hFFFF_FFFF, "R1 match");
    idle(1);
    chk(5'd12, 32'h0, "R1 stat");
    chk(5'd16, 32'h0, "R1 irq");

    // split, A periodic down, load 5
    wr(4'd0, 32'd4);
    wr(4'd2, 32'b010);
    wr(4'd4, 32'd5);
    wr(4'd1, 32'd1);           // edge E0
    idle(1);                    // E1
    chk(5'd10, 32'd5, "R2 start at load");
    idle(5);                    // E6
    chk(5'd10, 32'd0, "R2 reached zero");
    chk(5'd12, 32'h0, "R2 no early timeout");
    idle(1);                    // E7
    chk(5'd10, 32'd5, "R2 reload");
    chk(5'd12, 32'h1, "R2 timeout bit");
    idle(1);                    // E8
    chk(5'd10, 32'd4, "R5 keeps counting");
    wr(4'd15, 32'h1);           // E9
    chk(5'd12, 32'h0, "R11 clear");
    chk(5'd16, 32'h0, "R10 irq masked off");
    idle(3);                    // E12
    chk(5'd10, 32'd0, "R5 second pass");
    idle(1);                    // E13
    chk(5'd12, 32'h1, "R5 second timeout");
    wr(4'd13, 32'h1);           // E14
    chk(5'd14, 32'h1, "R10 masked stat");
    chk(5'd16, 32'h1, "R10 irq high");
    idle(4);                    // E18
    wr(4'd15, 32'h1);           // E19 clear meets timeout
    chk(5'd12, 32'h1, "R11 event wins");
    wr(4'd15, 32'h1);           // E20
    chk(5'd12, 32'h0, "R11 clear after");
    chk(5'd16, 32'h0, "R10 irq low");
    wr(4'd1, 32'd0);

    // A one-shot up, load 3, prescale 2 (ignored when up)
    wr(4'd15, 32'hF);
    wr(4'd4, 32'd3);
    wr(4'd2, 32'b101);
    wr(4'd8, 32'd2);
    wr(4'd1, 32'd1);            // F0
    idle(1);                    // F1
    chk(5'd10, 32'd0, "R3 start at zero");
    idle(3);                    // F4
    chk(5'd10, 32'd3, "R7 up ignores prescale");
    chk(5'd1, 32'd1, "R4 still enabled");
    idle(1);                    // F5
    chk(5'd10, 32'd0, "R3 wrap to zero");
    chk(5'd12, 32'h1, "R3 timeout");
    chk(5'd1, 32'd0, "R4 self disable");
    idle(3);
    chk(5'd10, 32'd0, "R4 stopped");

    // B periodic down, load 2, prescale 1, match 1
    wr(4'd15, 32'hF);
    wr(4'd3, 32'b010);
    wr(4'd5, 32'd2);
    wr(4'd9, 32'd1);
    wr(4'd7, 32'd1);
    wr(4'd1, 32'd2);            // G0
    idle(1);                    // G1
    chk(5'd11, 32'd2, "R2 B start");
    idle(1);                    // G2
    chk(5'd11, 32'd2, "R7 prescale hold");
    idle(1);                    // G3
    chk(5'd11, 32'd1, "R7 prescaled step");
    chk(5'd12, 32'h8, "R9 B match");
    idle(4);                    // G7
    chk(5'd11, 32'd2, "R7 B reload");
    chk(5'd12, 32'hC, "R2 B timeout");

    // reserved mode, value write
    wr(4'd1, 32'd0);
    wr(4'd2, 32'b000);
    wr(4'd10, 32'h0005_0007);
    chk(5'd10, 32'd7, "R12 low half only");
    wr(4'd1, 32'd1);
    idle(3);
    chk(5'd10, 32'd7, "R6 reserved mode idle");

    // joined 32-bit counter
    wr(4'd1, 32'd0);
    wr(4'd15, 32'hF);
    wr(4'd0, 32'd0);
    wr(4'd2, 32'b010);
    wr(4'd4, 32'h0001_0001);
    wr(4'd6, 32'h0000_FFFF);
    wr(4'd1, 32'd1);            // H0
    idle(1);                    // H1
    chk(5'd10, 32'h0001_0001, "R8 wide start");
    chk(5'd11, 32'h0000_0001, "R8 upper half");
    idle(2);                    // H3
    chk(5'd10, 32'h0000_FFFF, "R8 borrow across halves");
    chk(5'd11, 32'h0, "R8 upper after borrow");
    chk(5'd12, 32'h2, "R9 full-width match");

    ended = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule